// File: doc/BRIEF.md
# Dual Timer with Split Mode

This block holds two 8-bit-pair counters, Timer 0 and Timer 1, each with a selectable operating mode, a run bit, and a sticky overflow flag. Each timer counts one of two things. In timer mode it counts clocks: either every system clock, or only the cycles on which a prescaled tick is high. In counter mode it counts falling edges of an external input, which is first synchronized. Timer 0 also has a gate. When the gate is enabled, Timer 0 counts only while an external level, XORed with a polarity bit, is high. Software may load any count byte at any time and may clear either flag.

The modes are: a 13-bit counter, a 16-bit counter, and an 8-bit counter with auto-reload. A fourth mode applies to Timer 0 only and splits it into two independent 8-bit counters. In that split mode, the high byte of Timer 0 runs on Timer 1's run bit and sets Timer 1's flag. Timer 1 keeps counting, but only from clocks, and its run control moves to its mode field. Timer 1's overflow pulse is always produced, so that consumers such as baud-rate logic and conversion triggers keep working.

Top module: `dual_timer`

## Requirements
- R1: After reset, all four count bytes, both flags and the overflow pulse are 0.
- R2: Mode 0 (mode code 0) forms a 13-bit count from the high byte (upper 8 bits) and bits 4:0 of the low byte. Bits 7:5 of the low byte are left unchanged. On a wrap from 0x1FFF to 0, the timer's flag is set.
- R3: Mode 1 (mode code 1) is a 16-bit count {high, low}. A wrap from 0xFFFF to 0 sets the timer's flag.
- R4: Mode 2 (mode code 2) counts the low byte only. When the low byte is 0xFF, the next count loads it from the high byte and sets the flag. The high byte does not change.
- R5: In timer mode (counter select 0), a half with its fast select at 1 counts every clock. With fast select 0, it counts only on cycles where tick_pre is 1.
- R6: In counter mode (counter select 1), each falling edge of the external count input adds exactly one count. The count changes on the third rising clock edge after the input falls.
- R7: When gate_en0 is 1, Timer 0 counts only while run0 is 1 and gate_in0 XOR gate_pol0 is 1. When run0 is 0, Timer 0 never counts.
- R8: With mode0 = 3, lo0 is an 8-bit counter under the Timer 0 controls (run, gate, counter select, fast_lo0) and its wrap sets flag0. hi0 is an 8-bit clock-only counter that is enabled by run1, clocked according to fast_hi0, and whose wrap sets flag1.
- R9: With mode0 = 3, Timer 1 counts clocks in mode1 0, 1 or 2 regardless of run1 and ctr_sel1. Its overflows pulse t1_ovf but never set flag1.
- R10: With mode1 = 3, Timer 1 holds its count and never pulses t1_ovf, whatever the mode of Timer 0.
- R11: A flag stays set until its clear input is 1. An overflow in the same cycle as a clear leaves the flag set.
- R12: When wr_en is 1, wr_data replaces one byte at the next clock edge, overriding any count of that byte. The wr_sel codes are 0 for lo0, 1 for hi0, 2 for lo1 and 3 for hi1.
- R13: t1_ovf is high for exactly the one cycle in which Timer 1's wrapped count first appears. When mode0 is not 3, that same overflow also sets flag1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_pre | input | 1 | Prescaled clock tick, one cycle wide |
| ext_cnt0 | input | 1 | External count input of Timer 0 |
| ext_cnt1 | input | 1 | External count input of Timer 1 |
| gate_in0 | input | 1 | External gate level of Timer 0 |
| gate_pol0 | input | 1 | Gate polarity, XORed with gate_in0 |
| mode0 | input | 2 | Timer 0 mode code |
| ctr_sel0 | input | 1 | Timer 0 counts external edges when 1 |
| gate_en0 | input | 1 | Timer 0 gate enable |
| run0 | input | 1 | Timer 0 run bit |
| mode1 | input | 2 | Timer 1 mode code |
| ctr_sel1 | input | 1 | Timer 1 counts external edges when 1 |
| run1 | input | 1 | Timer 1 run bit (hi0 enable in split mode) |
| fast_lo0 | input | 1 | lo0 / Timer 0 clock select, 1 = every clock |
| fast_hi0 | input | 1 | hi0 clock select in split mode |
| fast1 | input | 1 | Timer 1 clock select |
| wr_en | input | 1 | Byte write strobe |
| wr_sel | input | 2 | Byte selected for write |
| wr_data | input | 8 | Write data |
| clr_flag0 | input | 1 | Clears flag0 |
| clr_flag1 | input | 1 | Clears flag1 |
| lo0 | output | 8 | Timer 0 low byte |
| hi0 | output | 8 | Timer 0 high byte |
| lo1 | output | 8 | Timer 1 low byte |
| hi1 | output | 8 | Timer 1 high byte |
| flag0 | output | 1 | Timer 0 overflow flag |
| flag1 | output | 1 | Timer 1 overflow flag |
| t1_ovf | output | 1 | Timer 1 overflow pulse |

## Verification
Some properties are checked on every cycle:
- the flags are sticky;
- a stopped Timer 0 and a Timer 1 parked in mode 3 hold still;
- in split mode, flag1 can only be set from a hi0 that is at 0xFF with run1 high.

The bench's scenarios compare the design against a behavioural model on every clock. Only they can show:
- the exact wrap values of the 13-bit, 16-bit and reload modes;
- the three-edge latency of external counting;
- gate polarity;
- the handover of run control in split mode;
- the priority of writes over counting.

// File: rtl/dual_timer.sv
module dual_timer (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_pre,
  input  logic       ext_cnt0,
  input  logic       ext_cnt1,
  input  logic       gate_in0,
  input  logic       gate_pol0,
  input  logic [1:0] mode0,
  input  logic       ctr_sel0,
  input  logic       gate_en0,
  input  logic       run0,
  input  logic [1:0] mode1,
  input  logic       ctr_sel1,
  input  logic       run1,
  input  logic       fast_lo0,
  input  logic       fast_hi0,
  input  logic       fast1,
  input  logic       wr_en,
  input  logic [1:0] wr_sel,
  input  logic [7:0] wr_data,
  input  logic       clr_flag0,
  input  logic       clr_flag1,
  output logic [7:0] lo0,
  output logic [7:0] hi0,
  output logic [7:0] lo1,
  output logic [7:0] hi1,
  output logic       flag0,
  output logic       flag1,
  output logic       t1_ovf
);

  function automatic logic [16:0] step(input logic [1:0] m, input logic [7:0] lo, input logic [7:0] hi);
    logic [13:0] s13;
    logic [16:0] s16;
    s13 = {1'b0, hi, lo[4:0]} + 14'd1;
    s16 = {1'b0, hi, lo} + 17'd1;
    case (m)
      2'd0:    step = {s13[13], s13[12:5], lo[7:5], s13[4:0]};
      2'd1:    step = s16;
      2'd2:    step = (lo == 8'hFF) ? {1'b1, hi, hi} : {1'b0, hi, lo + 8'd1};
      default: step = {1'b0, hi, lo};
    endcase
  endfunction

  logic [2:0] sy0, sy1;
  logic [7:0] nl0, nh0, nl1, nh1;
  logic       ov0, ovh, ov1;
  logic [16:0] n0, n1;

  wire split  = (mode0 == 2'd3);
  wire fall0  = sy0[2] & ~sy0[1];
  wire fall1  = sy1[2] & ~sy1[1];
  wire tmr1   = fast1 | tick_pre;
  wire go_lo0 = run0 & (~gate_en0 | (gate_in0 ^ gate_pol0)) & (ctr_sel0 ? fall0 : (fast_lo0 | tick_pre));
  wire go_hi0 = split & run1 & (fast_hi0 | tick_pre);
  wire go1    = (mode1 != 2'd3) & (split ? tmr1 : (run1 & (ctr_sel1 ? fall1 : tmr1)));

  assign n0 = step(mode0, lo0, hi0);
  assign n1 = step(mode1, lo1, hi1);

  always_comb begin
    {nh0, nl0} = {hi0, lo0};
    ov0 = 1'b0;
    ovh = 1'b0;
    if (split) begin
      if (go_lo0) {ov0, nl0} = {1'b0, lo0} + 9'd1;
      if (go_hi0) {ovh, nh0} = {1'b0, hi0} + 9'd1;
    end else if (go_lo0) begin
      {ov0, nh0, nl0} = n0;
    end
    {ov1, nh1, nl1} = go1 ? n1 : {1'b0, hi1, lo1};
    if (wr_en) begin
      case (wr_sel)
        2'd0: nl0 = wr_data;
        2'd1: nh0 = wr_data;
        2'd2: nl1 = wr_data;
        default: nh1 = wr_data;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy0    <= '0;
      sy1    <= '0;
      lo0    <= '0;
      hi0    <= '0;
      lo1    <= '0;
      hi1    <= '0;
      flag0  <= 1'b0;
      flag1  <= 1'b0;
      t1_ovf <= 1'b0;
    end else begin
      sy0    <= {sy0[1:0], ext_cnt0};
      sy1    <= {sy1[1:0], ext_cnt1};
      lo0    <= nl0;
      hi0    <= nh0;
      lo1    <= nl1;
      hi1    <= nh1;
      flag0  <= (flag0 & ~clr_flag0) | ov0;
      flag1  <= (flag1 & ~clr_flag1) | (split ? ovh : ov1);
      t1_ovf <= ov1;
    end
  end

endmodule

module dual_timer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode0,
  input logic [1:0] mode1,
  input logic       run0,
  input logic       run1,
  input logic       wr_en,
  input logic [1:0] wr_sel,
  input logic       clr_flag0,
  input logic       clr_flag1,
  input logic [7:0] lo0,
  input logic [7:0] hi0,
  input logic [7:0] lo1,
  input logic [7:0] hi1,
  input logic       flag0,
  input logic       flag1,
  input logic       t1_ovf
);
  AST_FLAG0_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (flag0 && !clr_flag0) |=> flag0); // R11
  AST_FLAG1_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (flag1 && !clr_flag1) |=> flag1); // R11
  AST_T0_STOPPED: assert property (@(posedge clk) disable iff (!rst_n) (!run0 && mode0 != 2'd3 && !(wr_en && !wr_sel[1])) |=> ($stable(lo0) && $stable(hi0))); // R7
  AST_SPLIT_FLAG1_SOURCE: assert property (@(posedge clk) disable iff (!rst_n) (mode0 == 2'd3 && !flag1 && (hi0 != 8'hFF || !run1)) |=> !flag1); // R9
  AST_T1_PARKED: assert property (@(posedge clk) disable iff (!rst_n) (mode1 == 2'd3 && !(wr_en && wr_sel[1])) |=> ($stable(lo1) && $stable(hi1) && !t1_ovf)); // R10
endmodule

bind dual_timer dual_timer_chk chk_i (
  .clk(clk), .rst_n(rst_n), .mode0(mode0), .mode1(mode1), .run0(run0), .run1(run1),
  .wr_en(wr_en), .wr_sel(wr_sel), .clr_flag0(clr_flag0), .clr_flag1(clr_flag1),
  .lo0(lo0), .hi0(hi0), .lo1(lo1), .hi1(hi1), .flag0(flag0), .flag1(flag1), .t1_ovf(t1_ovf)
);

// File: tb/dual_timer_tb_top.sv
`timescale 1ns/1ps
module dual_timer_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_pre = 0, ext_cnt0 = 1, ext_cnt1 = 1, gate_in0 = 0, gate_pol0 = 0;
  logic [1:0] mode0 = 0, mode1 = 0;
  logic ctr_sel0 = 0, gate_en0 = 0, run0 = 0, ctr_sel1 = 0, run1 = 0;
  logic fast_lo0 = 0, fast_hi0 = 0, fast1 = 0;
  logic wr_en = 0;
  logic [1:0] wr_sel = 0;
  logic [7:0] wr_data = 0;
  logic clr_flag0 = 0, clr_flag1 = 0;
  logic [7:0] lo0, hi0, lo1, hi1;
  logic flag0, flag1, t1_ovf;

  int checks = 0, errors = 0;
  string cur_req = "R1";
  bit done = 0;

  always #2 clk = ~clk;

  dual_timer dut_i (.*);

  // Behavioural reference model
  int m_lo0, m_hi0, m_lo1, m_hi1;
  bit m_f0, m_f1, m_p;
  bit e0[3], e1[3];

  function automatic void adv(input int m, inout int lo, inout int hi, output bit ov);
    int v;
    ov = 0;
    if (m == 0) begin
      v = hi * 32 + lo % 32 + 1;
      if (v == 8192) begin v = 0; ov = 1; end
      hi = v / 32;
      lo = (lo / 32) * 32 + v % 32;
    end else if (m == 1) begin
      v = hi * 256 + lo + 1;
      if (v == 65536) begin v = 0; ov = 1; end
      hi = v / 256;
      lo = v % 256;
    end else if (m == 2) begin
      if (lo == 255) begin lo = hi; ov = 1; end
      else lo = lo + 1;
    end
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lo0 = 0; m_hi0 = 0; m_lo1 = 0; m_hi1 = 0;
      m_f0 = 0; m_f1 = 0; m_p = 0;
      for (int k = 0; k < 3; k++) begin e0[k] = 0; e1[k] = 0; end
    end else begin
      bit ed0, ed1, c0, c1, ovl, ovh, ov1, split;
      ed0 = e0[2] && !e0[1];
      ed1 = e1[2] && !e1[1];
      e0[2] = e0[1]; e0[1] = e0[0]; e0[0] = ext_cnt0;
      e1[2] = e1[1]; e1[1] = e1[0]; e1[0] = ext_cnt1;
      split = (mode0 == 3);
      ovl = 0; ovh = 0; ov1 = 0;
      c0 = run0 && (!gate_en0 || (gate_in0 != gate_pol0)) && (ctr_sel0 ? ed0 : (fast_lo0 || tick_pre));
      if (split) begin
        if (c0) begin m_lo0 = (m_lo0 + 1) % 256; ovl = (m_lo0 == 0); end
        if (run1 && (fast_hi0 || tick_pre)) begin m_hi0 = (m_hi0 + 1) % 256; ovh = (m_hi0 == 0); end
      end else if (c0) adv(mode0, m_lo0, m_hi0, ovl);
      if (split) c1 = (mode1 != 3) && (fast1 || tick_pre);
      else c1 = run1 && (mode1 != 3) && (ctr_sel1 ? ed1 : (fast1 || tick_pre));
      if (c1) adv(mode1, m_lo1, m_hi1, ov1);
      if (wr_en) case (wr_sel)
        0: m_lo0 = wr_data;
        1: m_hi0 = wr_data;
        2: m_lo1 = wr_data;
        default: m_hi1 = wr_data;
      endcase
      m_f0 = (m_f0 && !clr_flag0) || ovl;
      m_f1 = (m_f1 && !clr_flag1) || (split ? ovh : ov1);
      m_p = ov1;
    end
  end

  // Compare on every clock, away from the active edge
  always @(negedge clk) if (rst_n && !done) begin
    logic [34:0] got, exp;
    got = {lo0, hi0, lo1, hi1, flag0, flag1, t1_ovf};
    exp = {8'(m_lo0), 8'(m_hi0), 8'(m_lo1), 8'(m_hi1), m_f0, m_f1, m_p};
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s model compare at %0t: got %h expected %h", cur_req, $time, got, exp);
    end
  end

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp, input string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    wr_en = 1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic clr_all();
    clr_flag0 = 1; clr_flag1 = 1;
    @(negedge clk);
    clr_flag0 = 0; clr_flag1 = 0;
  endtask

  task automatic ext_pulse(input bit which);
    if (which) ext_cnt1 = 0; else ext_cnt0 = 0;
    cyc(2);
    if (which) ext_cnt1 = 1; else ext_cnt0 = 1;
    cyc(3);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    done = 1;
    summary();
  end

  initial begin
    cyc(3);
    rst_n = 1;
    // R1 reset state
    cur_req = "R1";
    chk("R1", lo0, 0, "lo0"); chk("R1", hi0, 0, "hi0");
    chk("R1", lo1, 0, "lo1"); chk("R1", hi1, 0, "hi1");
    chk("R1", {5'd0, flag0, flag1, t1_ovf}, 0, "flags/pulse");
    mode1 = 3;

    // R3 16-bit wrap
    cur_req = "R3";
    mode0 = 1; fast_lo0 = 1;
    wr(0, 8'hF0); wr(1, 8'hFF);
    run0 = 1;
    cyc(15);
    chk("R3", lo0, 8'hFF, "lo0 before wrap"); chk("R3", {7'd0, flag0}, 0, "flag0 before wrap");
    cyc(1);
    run0 = 0;
    chk("R3", lo0, 0, "lo0 after wrap"); chk("R3", hi0, 0, "hi0 after wrap");
    chk("R3", {7'd0, flag0}, 1, "flag0 after wrap");
    clr_all();

    // R2 13-bit wrap keeps lo0[7:5]
    cur_req = "R2";
    mode0 = 0;
    wr(0, 8'hFC); wr(1, 8'hFF);
    run0 = 1; cyc(4); run0 = 0;
    chk("R2", lo0, 8'hE0, "lo0 after 13-bit wrap"); chk("R2", hi0, 0, "hi0");
    chk("R2", {7'd0, flag0}, 1, "flag0");
    clr_all();

    // R4 reload mode
    cur_req = "R4";
    mode0 = 2;
    wr(1, 8'hF0); wr(0, 8'hFD);
    run0 = 1; cyc(3);
    chk("R4", lo0, 8'hF0, "lo0 reloaded"); chk("R4", {7'd0, flag0}, 1, "flag0");
    cyc(2); run0 = 0;
    chk("R4", lo0, 8'hF2, "lo0 after reload"); chk("R4", hi0, 8'hF0, "hi0 unchanged");
    clr_all();

    // R5 prescaled tick
    cur_req = "R5";
    mode0 = 1; fast_lo0 = 0;
    wr(0, 0); wr(1, 0);
    run0 = 1;
    for (int i = 0; i < 12; i++) begin
      tick_pre = (i % 3 == 0);
      @(negedge clk);
    end
    tick_pre = 0;
    chk("R5", lo0, 4, "lo0 after four ticks");

    // R6 external edge counting with latency
    cur_req = "R6";
    ctr_sel0 = 1;
    ext_cnt0 = 0; cyc(2);
    chk("R6", lo0, 4, "lo0 two edges after fall");
    cyc(1);
    chk("R6", lo0, 5, "lo0 three edges after fall");
    ext_cnt0 = 1; cyc(3);
    ext_pulse(0); ext_pulse(0); cyc(4);
    chk("R6", lo0, 7, "lo0 after three falls");
    ctr_sel0 = 0; run0 = 0;

    // R7 gate
    cur_req = "R7";
    fast_lo0 = 1; gate_en0 = 1;
    wr(0, 0);
    run0 = 1; cyc(5);
    chk("R7", lo0, 0, "gate low");
    gate_in0 = 1; cyc(5);
    chk("R7", lo0, 5, "gate high");
    gate_pol0 = 1; cyc(3);
    chk("R7", lo0, 5, "gate inverted");
    gate_in0 = 0; cyc(2);
    chk("R7", lo0, 7, "inverted gate active");
    run0 = 0; cyc(3);
    chk("R7", lo0, 7, "run0 off");
    gate_en0 = 0; gate_pol0 = 0;
    clr_all();

    // R8 R9 R10 split mode
    cur_req = "R8";
    mode0 = 3; fast_hi0 = 1; fast1 = 1; ctr_sel1 = 1;
    wr(0, 8'hFE); wr(1, 8'hFC); wr(3, 8'hFD); wr(2, 8'hFE);
    mode1 = 2; run0 = 1; run1 = 1;
    cyc(2);
    chk("R8", lo0, 0, "lo0 split wrap"); chk("R8", {7'd0, flag0}, 1, "flag0 from lo0");
    chk("R9", {7'd0, t1_ovf}, 1, "t1 pulse in split"); chk("R9", {7'd0, flag1}, 0, "flag1 not set by timer 1");
    cyc(2);
    chk("R8", hi0, 0, "hi0 split wrap"); chk("R8", {7'd0, flag1}, 1, "flag1 from hi0");
    cur_req = "R9";
    run1 = 0; cyc(1);
    chk("R9", lo1, 8'hFD, "timer 1 runs without run1"); chk("R9", {7'd0, t1_ovf}, 1, "second pulse");
    chk("R8", hi0, 0, "hi0 stops with run1");
    cur_req = "R10";
    mode1 = 3; cyc(3);
    chk("R10", lo1, 8'hFD, "timer 1 parked in split"); chk("R10", {7'd0, t1_ovf}, 0, "no pulse parked");
    run0 = 0; mode0 = 1; ctr_sel1 = 0;
    clr_all();

    // R10 parked outside split
    run1 = 1; cyc(5);
    chk("R10", lo1, 8'hFD, "timer 1 parked, not split");

    // R13 pulse and flag1 outside split
    cur_req = "R13";
    run1 = 0; mode1 = 1;
    wr(2, 8'hFE); wr(3, 8'hFF);
    run1 = 1; cyc(2); run1 = 0;
    chk("R13", lo1, 0, "lo1 wrap"); chk("R13", hi1, 0, "hi1 wrap");
    chk("R13", {7'd0, flag1}, 1, "flag1"); chk("R13", {7'd0, t1_ovf}, 1, "pulse");
    cyc(1);
    chk("R13", {7'd0, t1_ovf}, 0, "pulse one cycle");

    // R11 sticky flag and overflow beating clear
    cur_req = "R11";
    cyc(3);
    chk("R11", {7'd0, flag1}, 1, "flag1 sticky");
    wr(2, 8'hFF); wr(3, 8'hFF);
    run1 = 1; clr_flag1 = 1; cyc(1); run1 = 0; clr_flag1 = 0;
    chk("R11", {7'd0, flag1}, 1, "overflow wins over clear");
    clr_flag1 = 1; cyc(1); clr_flag1 = 0;
    chk("R11", {7'd0, flag1}, 0, "flag1 cleared");

    // R12 write beats count
    cur_req = "R12";
    mode0 = 1; run0 = 1;
    wr_en = 1; wr_sel = 0; wr_data = 8'h80;
    @(negedge clk); wr_en = 0;
    chk("R12", lo0, 8'h80, "write overrides count");
    cyc(1); run0 = 0;
    chk("R12", lo0, 8'h81, "count resumes");

    // R6 Timer 1 external counting
    cur_req = "R6";
    mode1 = 1; ctr_sel1 = 1;
    wr(2, 0); wr(3, 0);
    run1 = 1;
    ext_pulse(1); ext_pulse(1); cyc(3);
    chk("R6", lo1, 2, "timer 1 external count");
    run1 = 0;

    cyc(2);
    done = 1;
    summary();
  end
endmodule